// File: doc/BRIEF.md
# Power-up reset sequencer with strap latching

This block takes a processor-style device from power-on to normal operation. An active-low reset, a power-good level and a clock-forward-reset level arrive asynchronously. Each passes through a two-flop synchronizer, and the synchronized values drive a four-state sequencer: settle, clock-forward reset, command idle and run. When power-good rises, the block captures the clock-ratio divisor from a set of static configuration straps. The PLL charge-pump enable follows the synchronized power-good level.

Each tristate-capable output pad has its own output enable. The enables stay off until the sequence reaches its late states. The command code on the outbound address/command bus moves through three phases: it is undefined after a power-up reset, a non-zero no-op code while the external clocks start, and the plain no-op code once the device runs. A warm reset, taken while power is good, leaves the last command in place. A power-up flag separates the two kinds of reset. The flag is set by any reset seen while power-good is low and cleared when the sequencer enters run.

Top module: `boot_sequencer`

## Requirements
- R1: While the synchronized reset is active, `seq_state_o` is 0 (settle) and every bit of `pad_oe_o` is 0.
- R2: A change on `rst_in_n`, `pwr_good_i` or `clk_fwd_rst_i` first shows at the outputs after the third rising clock edge that follows it (two synchronizer stages plus one state register).
- R3: Out of reset, the sequencer stays in settle (code 0) while power-good is low. Once power-good is high, the next cycle moves it to clock-forward reset (code 1).
- R4: `clk_div_o` takes the value of `strap_i` only in the cycle in which the synchronized power-good rises. At all other times it holds, including through a power-good drop and through reset.
- R5: `cp_en_o` is 1 exactly when the synchronized power-good was 1 at the previous clock edge. Reset has no effect on it.
- R6: In clock-forward reset, the sequencer waits until the clock-forward-reset input has been seen high and then low. It then enters command idle (code 2). In command idle, `cmd_o` equals the NZNOP code (default 15'h2A55) and `cmd_known_o` is 1.
- R7: Command idle lasts exactly RUN_DELAY cycles (default 8). The sequencer then enters run (code 3), and there `cmd_o` equals the NOP code (default 15'h7FFF) with `cmd_known_o` 1.
- R8: If the synchronized power-good is low and reset is not active, the sequencer returns to settle in the next cycle from any state.
- R9: A reset seen while power-good is low sets the power-up flag. While the flag is set, any reset cycle drives `cmd_known_o` to 0, and the flag stays set until run is entered.
- R10: A reset taken from run while power-good is high keeps `cmd_o` and `cmd_known_o` unchanged until command idle is entered again.
- R11: `pad_oe_o` bit 2 (outbound address clock) is 1 in command idle and run. Bits 0 (data bus), 1 (check bits), 3 (serial ROM clock), 4 (serial ROM enable) and 5 (test status) are 1 only in run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal clock, running from power-on |
| rst_in_n | input | 1 | Asynchronous active-low reset |
| pwr_good_i | input | 1 | Asynchronous power-good level |
| clk_fwd_rst_i | input | 1 | Asynchronous clock-forward-reset level |
| strap_i | input | DIV_W | Static configuration straps carrying the clock-ratio divisor |
| clk_div_o | output | DIV_W | Latched system-to-internal clock ratio divisor |
| cp_en_o | output | 1 | PLL charge-pump enable |
| pad_oe_o | output | 6 | Per-pad output enables, bit order as in R11 |
| cmd_o | output | CMD_W | Command code for the outbound address/command bus |
| cmd_known_o | output | 1 | 1 when `cmd_o` carries a defined code |
| seq_state_o | output | 2 | Sequencer state: 0 settle, 1 clock-forward reset, 2 command idle, 3 run |

## Verification
The interesting collision is a power-good drop in the same cycle that reset arrives. Synchronized power-good is low at the reset edge, so the block must treat it as a power-up reset: the command must go undefined and the sequencer must fall to settle. The bench provokes this by lowering both inputs at the same falling edge, and it also makes power-good rise while reset is still held. Each falling edge compares the outputs with a cycle model built from the requirements. That model decides which reset kind applies from the synchronized power-good it tracks itself.

// File: rtl/boot_seq_pkg.sv
`timescale 1ns/1ps
package boot_seq_pkg;

    typedef enum logic [1:0] {
        SEQ_SETTLE = 2'd0,
        SEQ_CFR    = 2'd1,
        SEQ_IDLE   = 2'd2,
        SEQ_RUN    = 2'd3
    } seq_state_e;

    // Output-enable bit positions
    localparam int OE_DATA      = 0;
    localparam int OE_CHECK     = 1;
    localparam int OE_ADDR_CLK  = 2;
    localparam int OE_SROM_CLK  = 3;
    localparam int OE_SROM_EN   = 4;
    localparam int OE_TEST_STAT = 5;
    localparam int OE_COUNT     = 6;

    // Enables that come on as soon as the external clocks start
    localparam logic [OE_COUNT-1:0] OE_EARLY_MASK = OE_COUNT'(1) << OE_ADDR_CLK;

endpackage

// File: rtl/bs_sync.sv
`timescale 1ns/1ps
module bs_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d;
    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    assign stg_d[0] = async_i;

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        assign stg_d[g] = stg_q[g-1];
    end

    always_ff @(posedge clk) begin
        stg_q <= stg_d;
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/bs_cfg_capture.sv
`timescale 1ns/1ps
module bs_cfg_capture #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             pg_s,
    input  logic [DIV_W-1:0] strap_i,
    output logic [DIV_W-1:0] div_o,
    output logic             cp_en_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             pg_prev;
        logic             cp_en;
    } cfg_t;

    cfg_t c_d, c_q;

    always_comb begin
        c_d         = c_q;
        c_d.pg_prev = pg_s;
        c_d.cp_en   = pg_s;
        if (pg_s && !c_q.pg_prev) begin
            c_d.div = strap_i;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign div_o   = c_q.div;
    assign cp_en_o = c_q.cp_en;
endmodule

// File: rtl/bs_seq_fsm.sv
`timescale 1ns/1ps
module bs_seq_fsm
    import boot_seq_pkg::*;
#(
    parameter int RUN_DELAY = 8
) (
    input  logic                clk,
    input  logic                rst_s,
    input  logic                pg_s,
    input  logic                cfr_s,
    output seq_state_e          state_q_o,
    output seq_state_e          state_d_o,
    output logic [OE_COUNT-1:0] pad_oe_o
);
    localparam int CNT_W = (RUN_DELAY > 1) ? $clog2(RUN_DELAY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_DELAY - 1);

    typedef struct packed {
        seq_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic                cfr_seen;
        logic [OE_COUNT-1:0] oe;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rst_s || !pg_s) begin
            s_d.state    = SEQ_SETTLE;
            s_d.cnt      = '0;
            s_d.cfr_seen = 1'b0;
        end else begin
            unique case (s_q.state)
                SEQ_SETTLE: begin
                    s_d.state = SEQ_CFR;
                end
                SEQ_CFR: begin
                    s_d.cfr_seen = s_q.cfr_seen | cfr_s;
                    if (s_q.cfr_seen && !cfr_s) begin
                        s_d.state    = SEQ_IDLE;
                        s_d.cnt      = '0;
                        s_d.cfr_seen = 1'b0;
                    end
                end
                SEQ_IDLE: begin
                    if (s_q.cnt == CNT_LAST) begin
                        s_d.state = SEQ_RUN;
                    end else begin
                        s_d.cnt = s_q.cnt + 1'b1;
                    end
                end
                default: begin
                    s_d.state = SEQ_RUN;
                end
            endcase
        end

        for (int i = 0; i < OE_COUNT; i++) begin
            s_d.oe[i] = (s_d.state == SEQ_RUN) ||
                        (OE_EARLY_MASK[i] && (s_d.state == SEQ_IDLE));
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign state_q_o = s_q.state;
    assign state_d_o = s_d.state;
    assign pad_oe_o  = s_q.oe;
endmodule

// File: rtl/bs_cmd_drive.sv
`timescale 1ns/1ps
module bs_cmd_drive
    import boot_seq_pkg::*;
#(
    parameter int               CMD_W      = 15,
    parameter logic [CMD_W-1:0] NZNOP_CODE = 15'h2A55,
    parameter logic [CMD_W-1:0] NOP_CODE   = 15'h7FFF
) (
    input  logic             clk,
    input  logic             rst_s,
    input  logic             pg_s,
    input  seq_state_e       state_d_i,
    output logic [CMD_W-1:0] cmd_o,
    output logic             known_o
);
    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic             known;
        logic             pwrup;
    } cmd_t;

    cmd_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        // Reset kind: power-up when power is not yet good
        if (rst_s && !pg_s) begin
            c_d.pwrup = 1'b1;
        end else if (state_d_i == SEQ_RUN) begin
            c_d.pwrup = 1'b0;
        end

        if (rst_s && c_d.pwrup) begin
            c_d.known = 1'b0;
        end else if (state_d_i == SEQ_IDLE) begin
            c_d.cmd   = NZNOP_CODE;
            c_d.known = 1'b1;
        end else if (state_d_i == SEQ_RUN) begin
            c_d.cmd   = NOP_CODE;
            c_d.known = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        c_q <= c_d;
    end

    assign cmd_o   = c_q.cmd;
    assign known_o = c_q.known;
endmodule

// File: rtl/boot_sequencer.sv
`timescale 1ns/1ps
module boot_sequencer
    import boot_seq_pkg::*;
#(
    parameter int               DIV_W       = 4,
    parameter int               CMD_W       = 15,
    parameter int               SYNC_STAGES = 2,
    parameter int               RUN_DELAY   = 8,
    parameter logic [CMD_W-1:0] NZNOP_CODE  = 15'h2A55,
    parameter logic [CMD_W-1:0] NOP_CODE    = 15'h7FFF
) (
    input  logic                clk,
    input  logic                rst_in_n,
    input  logic                pwr_good_i,
    input  logic                clk_fwd_rst_i,
    input  logic [DIV_W-1:0]    strap_i,
    output logic [DIV_W-1:0]    clk_div_o,
    output logic                cp_en_o,
    output logic [OE_COUNT-1:0] pad_oe_o,
    output logic [CMD_W-1:0]    cmd_o,
    output logic                cmd_known_o,
    output logic [1:0]          seq_state_o
);
    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] async_vec;
    logic [N_ASYNC-1:0] sync_vec;
    logic               rst_s;
    logic               pg_s;
    logic               cfr_s;
    seq_state_e         st_q;
    seq_state_e         st_d;

    assign async_vec = {clk_fwd_rst_i, pwr_good_i, ~rst_in_n};
    assign rst_s     = sync_vec[0];
    assign pg_s      = sync_vec[1];
    assign cfr_s     = sync_vec[2];

    bs_sync #(
        .WIDTH  (N_ASYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .async_i (async_vec),
        .sync_o  (sync_vec)
    );

    bs_cfg_capture #(
        .DIV_W (DIV_W)
    ) u_cfg (
        .clk     (clk),
        .pg_s    (pg_s),
        .strap_i (strap_i),
        .div_o   (clk_div_o),
        .cp_en_o (cp_en_o)
    );

    bs_seq_fsm #(
        .RUN_DELAY (RUN_DELAY)
    ) u_fsm (
        .clk       (clk),
        .rst_s     (rst_s),
        .pg_s      (pg_s),
        .cfr_s     (cfr_s),
        .state_q_o (st_q),
        .state_d_o (st_d),
        .pad_oe_o  (pad_oe_o)
    );

    bs_cmd_drive #(
        .CMD_W      (CMD_W),
        .NZNOP_CODE (NZNOP_CODE),
        .NOP_CODE   (NOP_CODE)
    ) u_cmd (
        .clk       (clk),
        .rst_s     (rst_s),
        .pg_s      (pg_s),
        .state_d_i (st_d),
        .cmd_o     (cmd_o),
        .known_o   (cmd_known_o)
    );

    assign seq_state_o = st_q;
endmodule

// File: rtl/bs_checker.sv
`timescale 1ns/1ps
module bs_checker #(
    parameter int               DIV_W      = 4,
    parameter int               CMD_W      = 15,
    parameter int               OE_N       = 6,
    parameter logic [CMD_W-1:0] NZNOP_CODE = 15'h2A55,
    parameter logic [CMD_W-1:0] NOP_CODE   = 15'h7FFF
) (
    input logic             clk,
    input logic             rst_s,
    input logic             pg_s,
    input logic [1:0]       state_i,
    input logic [OE_N-1:0]  pad_oe_i,
    input logic [CMD_W-1:0] cmd_i,
    input logic             cmd_known_i,
    input logic             cp_en_i,
    input logic [DIV_W-1:0] div_i
);
    logic [1:0] age_q = 2'd0;

    always_ff @(posedge clk) begin
        if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    // R1
    p_reset_settle_r1: assert property (@(posedge clk) disable iff (age_q == 2'd0)
        rst_s |=> (state_i == 2'd0) && (pad_oe_i == '0));

    // R4
    p_strap_hold_r4: assert property (@(posedge clk) disable iff (age_q != 2'd3)
        !$stable(div_i) |-> ($past(pg_s) && !$past(pg_s, 2)));

    // R5
    p_cp_follows_pg_r5: assert property (@(posedge clk) disable iff (age_q == 2'd0)
        cp_en_i == $past(pg_s));

    // R6
    p_idle_nznop_r6: assert property (@(posedge clk) disable iff (age_q == 2'd0)
        (state_i == 2'd2) |-> (cmd_known_i && (cmd_i == NZNOP_CODE)));

    // R7
    p_run_nop_r7: assert property (@(posedge clk) disable iff (age_q == 2'd0)
        (state_i == 2'd3) |-> (cmd_known_i && (cmd_i == NOP_CODE)));

    // R8
    p_pg_drop_r8: assert property (@(posedge clk) disable iff (age_q == 2'd0)
        !pg_s |=> (state_i == 2'd0));

    // R9
    p_pwrup_unknown_r9: assert property (@(posedge clk) disable iff (age_q == 2'd0)
        (rst_s && !pg_s) |=> !cmd_known_i);

    // R10
    p_warm_hold_r10: assert property (@(posedge clk) disable iff (age_q == 2'd0)
        (rst_s && pg_s && (state_i == 2'd3)) |=> (cmd_known_i && (cmd_i == NOP_CODE)));

    // R11
    p_oe_early_r11: assert property (@(posedge clk) disable iff (age_q == 2'd0)
        pad_oe_i[2] == state_i[1]);

    // R11
    p_oe_late_r11: assert property (@(posedge clk) disable iff (age_q == 2'd0)
        $countones(pad_oe_i) == ((state_i == 2'd3) ? OE_N : (state_i == 2'd2) ? 1 : 0));
endmodule

bind boot_sequencer bs_checker #(
    .DIV_W      (DIV_W),
    .CMD_W      (CMD_W),
    .OE_N       (6),
    .NZNOP_CODE (NZNOP_CODE),
    .NOP_CODE   (NOP_CODE)
) i_chk (
    .clk         (clk),
    .rst_s       (rst_s),
    .pg_s        (pg_s),
    .state_i     (seq_state_o),
    .pad_oe_i    (pad_oe_o),
    .cmd_i       (cmd_o),
    .cmd_known_i (cmd_known_o),
    .cp_en_i     (cp_en_o),
    .div_i       (clk_div_o)
);

// File: tb/test_boot_sequencer.sv
`timescale 1ns/1ps
module test_boot_sequencer;
    localparam int          DIV_W     = 4;
    localparam int          CMD_W     = 15;
    localparam int          RUN_DELAY = 8;
    localparam logic [14:0] NZNOP     = 15'h2A55;
    localparam logic [14:0] NOP       = 15'h7FFF;

    logic             clk = 1'b0;
    logic             rst_in_n = 1'b0;
    logic             pwr_good = 1'b0;
    logic             cfr = 1'b0;
    logic [DIV_W-1:0] strap = 4'h3;
    logic [DIV_W-1:0] clk_div;
    logic             cp_en;
    logic [5:0]       pad_oe;
    logic [CMD_W-1:0] cmd;
    logic             cmd_known;
    logic [1:0]       seq_state;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  chk_en   = 1'b0;
    bit  done     = 1'b0;

    always #2.5 clk = ~clk;

    boot_sequencer i_boot_sequencer (
        .clk           (clk),
        .rst_in_n      (rst_in_n),
        .pwr_good_i    (pwr_good),
        .clk_fwd_rst_i (cfr),
        .strap_i       (strap),
        .clk_div_o     (clk_div),
        .cp_en_o       (cp_en),
        .pad_oe_o      (pad_oe),
        .cmd_o         (cmd),
        .cmd_known_o   (cmd_known),
        .seq_state_o   (seq_state)
    );

    // ---------------- expected-value model ----------------
    logic [2:0]  m_s1 = '0, m_s2 = '0;   // {cfr, pg, rst}
    bit          m_pgprev = 0, m_cp = 0, m_div_ok = 0;
    logic [3:0]  m_div = '0;
    int          m_st = 0, m_cnt = 0;
    bit          m_seen = 0, m_pw = 0, m_known = 0, m_r = 0, m_pg = 0;
    logic [14:0] m_cmd = '0;
    logic [5:0]  m_oe = '0;

    function automatic logic [5:0] exp_oe(input int st);
        return (st == 3) ? 6'h3F : (st == 2) ? 6'h04 : 6'h00;
    endfunction

    always @(posedge clk) begin
        bit r, pg, cf;
        int ns;
        r = m_s2[0]; pg = m_s2[1]; cf = m_s2[2];
        m_r = r; m_pg = pg;
        if (pg && !m_pgprev) begin m_div = strap; m_div_ok = 1; end
        m_pgprev = pg;
        m_cp = pg;
        ns = m_st;
        if (r || !pg) begin ns = 0; m_cnt = 0; m_seen = 0; end
        else if (m_st == 0) ns = 1;
        else if (m_st == 1) begin
            if (m_seen && !cf) begin ns = 2; m_cnt = 0; m_seen = 0; end
            else m_seen = m_seen | cf;
        end else if (m_st == 2) begin
            if (m_cnt == RUN_DELAY - 1) ns = 3; else m_cnt = m_cnt + 1;
        end
        if (r && !pg) m_pw = 1; else if (ns == 3) m_pw = 0;
        if (r && m_pw) m_known = 0;
        else if (ns == 2) begin m_cmd = NZNOP; m_known = 1; end
        else if (ns == 3) begin m_cmd = NOP; m_known = 1; end
        m_st = ns;
        m_oe = exp_oe(ns);
        m_s2 = m_s1;
        m_s1 = {cfr, pwr_good, ~rst_in_n};
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (chk_en && !done) begin
            string t;
            t = m_r ? "R1" : (!m_pg ? "R8" : (m_st < 2) ? "R3" : (m_st == 2) ? "R6" : "R7");
            chk(seq_state == 2'(m_st), {t, " state"}, seq_state, m_st);
            chk(pad_oe == m_oe, m_r ? "R1 oe" : "R11 oe", pad_oe, m_oe);
            chk(cp_en == m_cp, "R5 cp_en", cp_en, m_cp);
            if (m_div_ok) chk(clk_div == m_div, "R4 divisor", clk_div, m_div);
            chk(cmd_known == m_known,
                !m_known ? "R9 known" : (m_st >= 2 ? "R6 known" : "R10 known"),
                cmd_known, m_known);
            if (m_known)
                chk(cmd == m_cmd, (m_st == 3) ? "R7 cmd" : (m_st == 2) ? "R6 cmd" : "R10 cmd",
                    cmd, m_cmd);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bring_up();
        rst_in_n = 1'b1;
        pwr_good = 1'b1;
        cyc(3 + int'($urandom % 3));
        cfr = 1'b1;
        cyc(1 + int'($urandom % 4));
        cfr = 1'b0;
        cyc(RUN_DELAY + 6);
    endtask

    initial begin
        void'($urandom(32'd4711));
        cyc(6);
        chk_en = 1'b1;
        // R2: power-good latency through the synchronizer
        strap = 4'h9;
        pwr_good = 1'b1;
        cyc(2);
        chk(cp_en == 1'b0, "R2 early cp_en", cp_en, 0);
        cyc(1);
        chk(cp_en == 1'b1, "R2 cp_en on third edge", cp_en, 1);
        chk(clk_div == 4'h9, "R4 strap at rise", clk_div, 9);
        cyc(4);
        // power-good rose during reset: command still undefined
        chk(cmd_known == 1'b0, "R9 pg during reset", cmd_known, 0);
        bring_up();
        chk(seq_state == 2'd3, "R7 reached run", seq_state, 3);

        for (int it = 0; it < 80; it++) begin
            int op;
            op = int'($urandom % 6);
            case (op)
                0: begin // warm reset
                    rst_in_n = 1'b0;
                    cyc(1 + int'($urandom % 6));
                    bring_up();
                end
                1: begin // full power-up reset
                    pwr_good = 1'b0;
                    rst_in_n = 1'b0;
                    cyc(4 + int'($urandom % 4));
                    strap = 4'($urandom);
                    pwr_good = 1'b1;
                    cyc(1 + int'($urandom % 5));
                    bring_up();
                end
                2: begin // power-good drop without reset
                    pwr_good = 1'b0;
                    cyc(1 + int'($urandom % 6));
                    strap = 4'($urandom);
                    bring_up();
                end
                3: begin // power-good drop in the same cycle as reset
                    pwr_good = 1'b0;
                    rst_in_n = 1'b0;
                    cyc(3 + int'($urandom % 4));
                    strap = 4'($urandom);
                    bring_up();
                end
                4: begin // straps move while power is good
                    strap = 4'($urandom);
                    cyc(2 + int'($urandom % 5));
                end
                default: begin // stray clock-forward pulses in run
                    cfr = 1'($urandom);
                    cyc(1 + int'($urandom % 3));
                    cfr = 1'b0;
                    cyc(2);
                end
            endcase
        end
        cyc(4);
        chk(seq_state == 2'd3, "R7 final run", seq_state, 3);
        chk(cmd == NOP, "R7 final NOP", cmd, NOP);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule